// File: doc/BRIEF.md
# DMA Completion Interrupt Vector Controller

This block gathers completion events from a multichannel transmit DMA and a multichannel receive DMA, plus two MAC-level sources (a host-error event and a status event), and turns them into a single interrupt line and an encoded vector word. Every source has a sticky pending bit and an enable bit. The interrupt is the OR of all enabled pending bits. The vector tells software, in one read, which transmit channel and which receive channel need service and whether either MAC-level source is active.

Software services an interrupt in three steps. It reads the vector. It writes the per-channel acknowledge address of each channel it has handled, which clears that channel's pending bit. It then writes the end-of-interrupt address. The line latches high once raised and ignores acknowledges. Only the end-of-interrupt write drops it. After one cycle low, it rises again if anything enabled is still pending.

The only interface is a register port with a combinational read path. The DMA engines and the MAC are outside the block; they appear as single-cycle event pulses.

Top module: `dma_irq_vector`

## Requirements
- R1: Reset behaviour. After reset all pending bits and all enable bits are 0, `irq_o` is low, and every register reads 0.
- R2: Event capture. A pulse on `tx_done_i[k]` or `rx_done_i[k]` sets that channel's pending bit at that clock edge. The bit stays set until the channel is acknowledged. Transmit pending bits read at address 0x00 and receive pending bits at 0x04, with channel k in bit k.
- R3: Per-channel acknowledge. A write of any value to 0x20+k clears transmit channel k, and a write to 0x28+k clears receive channel k. No other bit changes. If an event and an acknowledge hit the same channel in the same cycle, the bit stays set.
- R4: Enable registers.
  - A write to an enable address (transmit 0x02, receive 0x06, MAC 0x0A) sets the enable bits where the write data has ones, so writing 0xFF unmasks all eight channels.
  - A write to the matching clear address (0x03, 0x07, 0x0B) clears the enable bits where the write data has ones.
  - Both addresses read back the current enable mask.
- R5: Masked status. Addresses 0x01 (transmit), 0x05 (receive) and 0x09 (MAC) read pending AND enable.
- R6: Vector word at 0x0C.
  - Bit 16 is set when any transmit channel is pending and enabled, and bits 2:0 give the lowest-numbered such channel.
  - Bit 17 and bits 10:8 do the same for receive.
  - Bit 18 is the enabled host-error source and bit 19 is the enabled status source.
  - All other bits are 0, and a channel field is 0 when its flag is clear.
- R7: MAC-level sources. A pulse on `host_err_i` sets MAC pending bit 0 and a pulse on `stat_evt_i` sets MAC pending bit 1, both readable at 0x08. Writing ones to 0x08 clears the matching bits, and a new event in the same cycle wins.
- R8: Interrupt assertion. While `irq_o` is low, it rises at the clock edge after any enabled pending bit is present. Once high, it stays high through acknowledges and mask changes until an end-of-interrupt write.
- R9: End of interrupt. A write to 0x0D drives `irq_o` low at that edge for exactly one cycle. At the next edge `irq_o` takes the OR of the enabled pending bits at that moment.
- R10: Unmapped space. Reads of unmapped addresses return 0, and writes to them, or to read-only addresses, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_done_i | input | NCH | Per-channel transmit completion pulses |
| rx_done_i | input | NCH | Per-channel receive completion pulses |
| host_err_i | input | 1 | Host-error event pulse |
| stat_evt_i | input | 1 | Status event pulse |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 8 | Register word address for reads and writes |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| irq_o | output | 1 | Latched interrupt line |

## Verification
The bench builds the block with its default of eight channels per direction. This brings into reach:
- channel 7 in both directions,
- all three bits of each vector channel field,
- the whole acknowledge window from 0x20 to 0x2F.

The reference model runs beside the design and is compared on every cycle. Directed phases cover the lowest-channel choice, event-versus-acknowledge collisions, and the end-of-interrupt sequence with and without sources still pending. A long pseudo-random phase then mixes events, enable changes, acknowledges and end-of-interrupt writes so that they interleave in orders the directed phases do not reach.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int FIELD_W = 3;
    localparam int MAC_N   = 2;

    localparam int TX_FLAG_BIT  = 16;
    localparam int RX_FLAG_BIT  = 17;
    localparam int HOST_FLAG_BIT = 18;
    localparam int STAT_FLAG_BIT = 19;
    localparam int TX_FIELD_LSB = 0;
    localparam int RX_FIELD_LSB = 8;

    localparam logic [ADDR_W-1:0] A_TX_RAW  = 8'h00;
    localparam logic [ADDR_W-1:0] A_TX_MSK  = 8'h01;
    localparam logic [ADDR_W-1:0] A_TX_EN   = 8'h02;
    localparam logic [ADDR_W-1:0] A_TX_CLR  = 8'h03;
    localparam logic [ADDR_W-1:0] A_RX_RAW  = 8'h04;
    localparam logic [ADDR_W-1:0] A_RX_MSK  = 8'h05;
    localparam logic [ADDR_W-1:0] A_RX_EN   = 8'h06;
    localparam logic [ADDR_W-1:0] A_RX_CLR  = 8'h07;
    localparam logic [ADDR_W-1:0] A_MAC_RAW = 8'h08;
    localparam logic [ADDR_W-1:0] A_MAC_MSK = 8'h09;
    localparam logic [ADDR_W-1:0] A_MAC_EN  = 8'h0A;
    localparam logic [ADDR_W-1:0] A_MAC_CLR = 8'h0B;
    localparam logic [ADDR_W-1:0] A_VECTOR  = 8'h0C;
    localparam logic [ADDR_W-1:0] A_EOI     = 8'h0D;
    localparam logic [ADDR_W-1:0] A_TX_ACK  = 8'h20;
    localparam logic [ADDR_W-1:0] A_RX_ACK  = 8'h28;

    typedef enum logic [4:0] {
        SEL_NONE,
        SEL_TX_RAW, SEL_TX_MSK, SEL_TX_EN, SEL_TX_CLR,
        SEL_RX_RAW, SEL_RX_MSK, SEL_RX_EN, SEL_RX_CLR,
        SEL_MAC_RAW, SEL_MAC_MSK, SEL_MAC_EN, SEL_MAC_CLR,
        SEL_VECTOR, SEL_EOI, SEL_TX_ACK, SEL_RX_ACK
    } reg_sel_e;

    typedef struct packed {
        logic               tx_pend;
        logic [FIELD_W-1:0] tx_ch;
        logic               rx_pend;
        logic [FIELD_W-1:0] rx_ch;
        logic               host;
        logic               stat;
    } vec_fields_t;

    function automatic logic in_ack_window(input logic [ADDR_W-1:0] a,
                                           input logic [ADDR_W-1:0] base,
                                           input int nch);
        return (a[ADDR_W-1:FIELD_W] == base[ADDR_W-1:FIELD_W]) &&
               (int'(a[FIELD_W-1:0]) < nch);
    endfunction

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a,
                                             input int nch);
        reg_sel_e s;
        case (a)
            A_TX_RAW:  s = SEL_TX_RAW;
            A_TX_MSK:  s = SEL_TX_MSK;
            A_TX_EN:   s = SEL_TX_EN;
            A_TX_CLR:  s = SEL_TX_CLR;
            A_RX_RAW:  s = SEL_RX_RAW;
            A_RX_MSK:  s = SEL_RX_MSK;
            A_RX_EN:   s = SEL_RX_EN;
            A_RX_CLR:  s = SEL_RX_CLR;
            A_MAC_RAW: s = SEL_MAC_RAW;
            A_MAC_MSK: s = SEL_MAC_MSK;
            A_MAC_EN:  s = SEL_MAC_EN;
            A_MAC_CLR: s = SEL_MAC_CLR;
            A_VECTOR:  s = SEL_VECTOR;
            A_EOI:     s = SEL_EOI;
            default: begin
                if (in_ack_window(a, A_TX_ACK, nch))
                    s = SEL_TX_ACK;
                else if (in_ack_window(a, A_RX_ACK, nch))
                    s = SEL_RX_ACK;
                else
                    s = SEL_NONE;
            end
        endcase
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] pack_vector(input vec_fields_t f);
        logic [DATA_W-1:0] v;
        v = '0;
        v[TX_FLAG_BIT]   = f.tx_pend;
        v[RX_FLAG_BIT]   = f.rx_pend;
        v[HOST_FLAG_BIT] = f.host;
        v[STAT_FLAG_BIT] = f.stat;
        v[TX_FIELD_LSB +: FIELD_W] = f.tx_ch;
        v[RX_FIELD_LSB +: FIELD_W] = f.rx_ch;
        return v;
    endfunction

endpackage

// File: rtl/dmairq_bank.sv
module dmairq_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] en_set_i,
    input  logic [N-1:0] en_clr_i,
    output logic [N-1:0] raw_o,
    output logic [N-1:0] en_o
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        // A fresh event overrides a same-cycle clear.
        always_ff @(posedge clk) begin
            if (rst)
                raw_o[g] <= 1'b0;
            else if (evt_i[g])
                raw_o[g] <= 1'b1;
            else if (clr_i[g])
                raw_o[g] <= 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst)
                en_o[g] <= 1'b0;
            else if (en_set_i[g])
                en_o[g] <= 1'b1;
            else if (en_clr_i[g])
                en_o[g] <= 1'b0;
        end
    end

endmodule

// File: rtl/dmairq_lowest.sv
module dmairq_lowest #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     vec_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        valid_o = |vec_i;
        idx_o   = '0;
        // Scan downward so that the lowest set bit is assigned last.
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i])
                idx_o = IDX_W'(i);
        end
    end

endmodule

// File: rtl/dmairq_line.sv
module dmairq_line (
    input  logic clk,
    input  logic rst,
    input  logic any_i,
    input  logic eoi_i,
    output logic irq_o
);

    // Latched line: it rises on any source and falls only on end-of-interrupt.
    always_ff @(posedge clk) begin
        if (rst)
            irq_o <= 1'b0;
        else if (eoi_i)
            irq_o <= 1'b0;
        else if (!irq_o)
            irq_o <= any_i;
    end

endmodule

// File: rtl/dma_irq_vector.sv
module dma_irq_vector
    import dmairq_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    tx_done_i,
    input  logic [NCH-1:0]    rx_done_i,
    input  logic              host_err_i,
    input  logic              stat_evt_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);

    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [NCH-1:0] ONE_CH = NCH'(1);

    reg_sel_e          sel;
    logic [IDX_W-1:0]  ack_idx;
    logic [NCH-1:0]    tx_raw, tx_en, rx_raw, rx_en;
    logic [NCH-1:0]    tx_ack_clr, rx_ack_clr;
    logic [NCH-1:0]    tx_en_set, tx_en_clr, rx_en_set, rx_en_clr;
    logic [MAC_N-1:0]  mac_raw, mac_en, mac_evt, mac_w1c, mac_en_set, mac_en_clr;
    logic [NCH-1:0]    tx_msk, rx_msk;
    logic [MAC_N-1:0]  mac_msk;
    vec_fields_t       vf;
    logic [DATA_W-1:0] vec_word;
    logic              any_src;
    logic              eoi_wr;

    assign sel     = decode_addr(reg_addr_i, NCH);
    assign ack_idx = reg_addr_i[IDX_W-1:0];

    // Write-side strobes.
    always_comb begin
        tx_ack_clr = '0;
        rx_ack_clr = '0;
        tx_en_set  = '0;
        tx_en_clr  = '0;
        rx_en_set  = '0;
        rx_en_clr  = '0;
        mac_w1c    = '0;
        mac_en_set = '0;
        mac_en_clr = '0;
        if (reg_wr_i) begin
            case (sel)
                SEL_TX_ACK:  tx_ack_clr = ONE_CH << ack_idx;
                SEL_RX_ACK:  rx_ack_clr = ONE_CH << ack_idx;
                SEL_TX_EN:   tx_en_set  = reg_wdata_i[NCH-1:0];
                SEL_TX_CLR:  tx_en_clr  = reg_wdata_i[NCH-1:0];
                SEL_RX_EN:   rx_en_set  = reg_wdata_i[NCH-1:0];
                SEL_RX_CLR:  rx_en_clr  = reg_wdata_i[NCH-1:0];
                SEL_MAC_RAW: mac_w1c    = reg_wdata_i[MAC_N-1:0];
                SEL_MAC_EN:  mac_en_set = reg_wdata_i[MAC_N-1:0];
                SEL_MAC_CLR: mac_en_clr = reg_wdata_i[MAC_N-1:0];
                default: ;
            endcase
        end
    end

    assign eoi_wr  = reg_wr_i && (sel == SEL_EOI);
    assign mac_evt = {stat_evt_i, host_err_i};

    dmairq_bank #(.N(NCH)) u_tx_bank (
        .clk(clk), .rst(rst), .evt_i(tx_done_i), .clr_i(tx_ack_clr),
        .en_set_i(tx_en_set), .en_clr_i(tx_en_clr),
        .raw_o(tx_raw), .en_o(tx_en)
    );

    dmairq_bank #(.N(NCH)) u_rx_bank (
        .clk(clk), .rst(rst), .evt_i(rx_done_i), .clr_i(rx_ack_clr),
        .en_set_i(rx_en_set), .en_clr_i(rx_en_clr),
        .raw_o(rx_raw), .en_o(rx_en)
    );

    dmairq_bank #(.N(MAC_N)) u_mac_bank (
        .clk(clk), .rst(rst), .evt_i(mac_evt), .clr_i(mac_w1c),
        .en_set_i(mac_en_set), .en_clr_i(mac_en_clr),
        .raw_o(mac_raw), .en_o(mac_en)
    );

    assign tx_msk  = tx_raw & tx_en;
    assign rx_msk  = rx_raw & rx_en;
    assign mac_msk = mac_raw & mac_en;

    logic               tx_valid, rx_valid;
    logic [FIELD_W-1:0] tx_ch, rx_ch;

    dmairq_lowest #(.N(NCH), .IDX_W(FIELD_W)) u_tx_enc (
        .vec_i(tx_msk), .valid_o(tx_valid), .idx_o(tx_ch)
    );

    dmairq_lowest #(.N(NCH), .IDX_W(FIELD_W)) u_rx_enc (
        .vec_i(rx_msk), .valid_o(rx_valid), .idx_o(rx_ch)
    );

    always_comb begin
        vf.tx_pend = tx_valid;
        vf.tx_ch   = tx_ch;
        vf.rx_pend = rx_valid;
        vf.rx_ch   = rx_ch;
        vf.host    = mac_msk[0];
        vf.stat    = mac_msk[1];
    end

    assign vec_word = pack_vector(vf);
    assign any_src  = tx_valid | rx_valid | (|mac_msk);

    dmairq_line u_line (
        .clk(clk), .rst(rst), .any_i(any_src), .eoi_i(eoi_wr), .irq_o(irq_o)
    );

    // Read path.
    always_comb begin
        case (sel)
            SEL_TX_RAW:              reg_rdata_o = DATA_W'(tx_raw);
            SEL_TX_MSK:              reg_rdata_o = DATA_W'(tx_msk);
            SEL_TX_EN, SEL_TX_CLR:   reg_rdata_o = DATA_W'(tx_en);
            SEL_RX_RAW:              reg_rdata_o = DATA_W'(rx_raw);
            SEL_RX_MSK:              reg_rdata_o = DATA_W'(rx_msk);
            SEL_RX_EN, SEL_RX_CLR:   reg_rdata_o = DATA_W'(rx_en);
            SEL_MAC_RAW:             reg_rdata_o = DATA_W'(mac_raw);
            SEL_MAC_MSK:             reg_rdata_o = DATA_W'(mac_msk);
            SEL_MAC_EN, SEL_MAC_CLR: reg_rdata_o = DATA_W'(mac_en);
            SEL_VECTOR:              reg_rdata_o = vec_word;
            default:                 reg_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/dmairq_chk.sv
module dmairq_chk
    import dmairq_pkg::*;
#(
    parameter int NCH = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              irq_o,
    input logic              reg_wr_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [NCH-1:0]    tx_done_i,
    input logic [NCH-1:0]    tx_raw,
    input logic [NCH-1:0]    tx_en,
    input logic [NCH-1:0]    rx_raw,
    input logic [NCH-1:0]    rx_en,
    input logic [MAC_N-1:0]  mac_raw,
    input logic [MAC_N-1:0]  mac_en,
    input logic [DATA_W-1:0] vec_word
);

    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

    logic eoi_seen;
    logic tx_ack_seen;
    logic any_pend;

    assign eoi_seen    = reg_wr_i && (reg_addr_i == A_EOI);
    assign tx_ack_seen = reg_wr_i && in_ack_window(reg_addr_i, A_TX_ACK, NCH);
    assign any_pend    = |(tx_raw & tx_en) || |(rx_raw & rx_en) || |(mac_raw & mac_en);

    // R9: the end-of-interrupt write pulls the line low at the next edge.
    assert_eoi_drop_R9: assert property (@(posedge clk) disable iff (rst)
        eoi_seen |=> !irq_o);

    // R8: a raised line holds until an end-of-interrupt write.
    assert_irq_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !eoi_seen) |=> irq_o);

    // R8: the line only rises when an enabled source was pending.
    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(any_pend));

    // R2: every transmit completion pulse leaves its pending bit set.
    assert_evt_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (|tx_done_i) |=> ((tx_raw & $past(tx_done_i)) == $past(tx_done_i)));

    // R3: an acknowledge without a colliding event clears the channel.
    assert_ack_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (tx_ack_seen && !tx_done_i[reg_addr_i[IDX_W-1:0]])
        |=> !tx_raw[$past(reg_addr_i[IDX_W-1:0])]);

    // R6: the reported transmit channel is really pending and enabled.
    assert_vec_points_R6: assert property (@(posedge clk) disable iff (rst)
        vec_word[TX_FLAG_BIT] |->
            (tx_raw[vec_word[IDX_W-1:0]] && tx_en[vec_word[IDX_W-1:0]]));

endmodule

bind dma_irq_vector dmairq_chk #(.NCH(NCH)) u_dmairq_chk (
    .clk(clk), .rst(rst), .irq_o(irq_o), .reg_wr_i(reg_wr_i),
    .reg_addr_i(reg_addr_i), .tx_done_i(tx_done_i),
    .tx_raw(tx_raw), .tx_en(tx_en), .rx_raw(rx_raw), .rx_en(rx_en),
    .mac_raw(mac_raw), .mac_en(mac_en), .vec_word(vec_word)
);

// File: tb/dma_irq_vector_tb_top.sv
`timescale 1ns/100ps
module dma_irq_vector_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  tx_done = '0;
    logic [7:0]  rx_done = '0;
    logic        host_err = 1'b0;
    logic        stat_evt = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  addr = 8'h0C;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int   n_checks = 0;
    int   n_fails  = 0;
    int   cycles   = 0;
    logic [7:0] view = 8'h0C;
    string tag_force = "";

    // Behavioural reference state.
    logic [7:0] m_txr = '0, m_txe = '0, m_rxr = '0, m_rxe = '0;
    logic [1:0] m_macr = '0, m_mace = '0;
    logic       m_irq = 1'b0;
    logic       m_eoi_prev = 1'b0;

    always #2.5 clk = ~clk;

    dma_irq_vector #(.NCH(8)) dut_i (
        .clk(clk), .rst(rst), .tx_done_i(tx_done), .rx_done_i(rx_done),
        .host_err_i(host_err), .stat_evt_i(stat_evt), .reg_wr_i(wr),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .irq_o(irq)
    );

    function automatic int lowest(input logic [7:0] v);
        for (int i = 0; i < 8; i++)
            if (v[i]) return i;
        return 0;
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        logic [31:0] r;
        r = '0;
        case (a)
            8'h00: r[7:0] = m_txr;
            8'h01: r[7:0] = m_txr & m_txe;
            8'h02, 8'h03: r[7:0] = m_txe;
            8'h04: r[7:0] = m_rxr;
            8'h05: r[7:0] = m_rxr & m_rxe;
            8'h06, 8'h07: r[7:0] = m_rxe;
            8'h08: r[1:0] = m_macr;
            8'h09: r[1:0] = m_macr & m_mace;
            8'h0A, 8'h0B: r[1:0] = m_mace;
            8'h0C: begin
                if ((m_txr & m_txe) != 0) begin
                    r[16] = 1'b1;
                    r[2:0] = 3'(lowest(m_txr & m_txe));
                end
                if ((m_rxr & m_rxe) != 0) begin
                    r[17] = 1'b1;
                    r[10:8] = 3'(lowest(m_rxr & m_rxe));
                end
                r[18] = m_macr[0] & m_mace[0];
                r[19] = m_macr[1] & m_mace[1];
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string tag_for(input logic [7:0] a);
        if (tag_force != "") return tag_force;
        case (a)
            8'h00, 8'h04: return "R2";
            8'h08: return "R7";
            8'h01, 8'h05, 8'h09: return "R5";
            8'h02, 8'h03, 8'h06, 8'h07, 8'h0A, 8'h0B: return "R4";
            8'h0C: return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", req, cycles, act, exp);
        end
    endtask

    // Reference model update, one step per clock edge.
    always @(posedge clk) begin
        logic any;
        logic eoi;
        logic [7:0] tclr, rclr;
        logic [1:0] mclr;
        cycles++;
        if (rst) begin
            m_txr = '0; m_txe = '0; m_rxr = '0; m_rxe = '0;
            m_macr = '0; m_mace = '0; m_irq = 1'b0; m_eoi_prev = 1'b0;
        end else begin
            any = ((m_txr & m_txe) != 0) || ((m_rxr & m_rxe) != 0) ||
                  ((m_macr & m_mace) != 0);
            eoi = wr && (addr == 8'h0D);
            if (eoi) m_irq = 1'b0;
            else if (!m_irq) m_irq = any;
            m_eoi_prev = eoi;
            tclr = (wr && addr >= 8'h20 && addr < 8'h28) ? (8'd1 << addr[2:0]) : 8'd0;
            rclr = (wr && addr >= 8'h28 && addr < 8'h30) ? (8'd1 << addr[2:0]) : 8'd0;
            mclr = (wr && addr == 8'h08) ? wdata[1:0] : 2'd0;
            m_txr  = (m_txr & ~tclr) | tx_done;
            m_rxr  = (m_rxr & ~rclr) | rx_done;
            m_macr = (m_macr & ~mclr) | {stat_evt, host_err};
            if (wr && addr == 8'h02) m_txe = m_txe | wdata[7:0];
            if (wr && addr == 8'h03) m_txe = m_txe & ~wdata[7:0];
            if (wr && addr == 8'h06) m_rxe = m_rxe | wdata[7:0];
            if (wr && addr == 8'h07) m_rxe = m_rxe & ~wdata[7:0];
            if (wr && addr == 8'h0A) m_mace = m_mace | wdata[1:0];
            if (wr && addr == 8'h0B) m_mace = m_mace & ~wdata[1:0];
        end
    end

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            check(irq === m_irq, m_eoi_prev ? "R9" : "R8",
                  {31'd0, irq}, {31'd0, m_irq});
            check(rdata === exp_read(addr), tag_for(addr), rdata, exp_read(addr));
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cycles > 20000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    task automatic drive(input logic [7:0] t, input logic [7:0] r, input logic [1:0] m,
                         input logic w, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        tx_done = t; rx_done = r; host_err = m[0]; stat_evt = m[1];
        wr = w; addr = w ? a : view; wdata = d;
        @(negedge clk); #1;
        tx_done = '0; rx_done = '0; host_err = 1'b0; stat_evt = 1'b0;
        wr = 1'b0; addr = view; wdata = '0;
    endtask

    task automatic wreg(input logic [7:0] a, input logic [31:0] d);
        drive(8'h00, 8'h00, 2'b00, 1'b1, a, d);
    endtask

    task automatic look(input logic [7:0] a);
        @(negedge clk); #1;
        view = a; addr = a;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] lfsr;
        logic [7:0]  wa;

        // R1: reset state seen through the read port and the line.
        repeat (3) @(negedge clk);
        for (int a = 0; a < 14; a++) begin
            addr = 8'(a);
            #1;
            check(rdata === 32'd0, "R1", rdata, 32'd0);
        end
        check(irq === 1'b0, "R1", {31'd0, irq}, 32'd0);
        addr = view;
        @(negedge clk); #1;
        rst = 1'b0;

        // R2 and R5: events captured while masked; the line stays low.
        look(8'h00);
        drive(8'h24, 8'h00, 2'b00, 1'b0, 8'h00, 0);
        look(8'h01);
        idle(2);

        // R4: unmask all transmit channels; vector reports channel 2.
        look(8'h0C);
        wreg(8'h02, 32'hFF);
        idle(2);

        // Receive channel 7 via a partial enable.
        drive(8'h00, 8'h80, 2'b00, 1'b0, 8'h00, 0);
        wreg(8'h06, 32'hC0);
        idle(2);

        // R3: acknowledge channel 2; vector moves to 5; the line holds (R8).
        tag_force = "R3";
        wreg(8'h22, 32'h0);
        look(8'h00);
        idle(1);
        look(8'h0C);
        tag_force = "";

        // R9: EOI with sources pending -> low one cycle then back high.
        wreg(8'h0D, 32'h0);
        idle(3);

        // Drain and EOI -> the line stays low.
        tag_force = "R3";
        wreg(8'h25, 32'h1234);
        wreg(8'h2F, 32'h0);
        tag_force = "";
        wreg(8'h0D, 32'h0);
        idle(3);

        // R3: event and acknowledge on the same channel in one cycle.
        tag_force = "R3";
        look(8'h00);
        drive(8'h08, 8'h00, 2'b00, 1'b1, 8'h23, 32'h0);
        idle(1);
        tag_force = "";
        look(8'h01);
        wreg(8'h03, 32'h08);
        wreg(8'h23, 32'h0);
        wreg(8'h0D, 32'h0);
        idle(2);

        // R7: MAC-level sources.
        look(8'h08);
        drive(8'h00, 8'h00, 2'b01, 1'b0, 8'h00, 0);
        idle(2);
        look(8'h0C);
        wreg(8'h0A, 32'h3);
        drive(8'h00, 8'h00, 2'b10, 1'b0, 8'h00, 0);
        idle(1);
        wreg(8'h08, 32'h1);
        look(8'h08);
        drive(8'h00, 8'h00, 2'b01, 1'b1, 8'h08, 32'h1);
        wreg(8'h08, 32'h3);
        wreg(8'h0B, 32'h2);
        look(8'h0A);
        wreg(8'h0D, 32'h0);
        idle(2);

        // R10: unmapped addresses and read-only registers ignore writes.
        tag_force = "R10";
        wreg(8'h30, 32'hFFFF_FFFF);
        wreg(8'h1F, 32'hFFFF_FFFF);
        wreg(8'h00, 32'hFF);
        wreg(8'h0C, 32'hFFFF_FFFF);
        look(8'h0E);
        idle(1);
        look(8'h30);
        idle(1);
        tag_force = "";
        look(8'h00);
        idle(1);
        look(8'h0C);
        idle(1);

        // Mixed pseudo-random traffic.
        lfsr = 32'hACE1_2468;
        for (int it = 0; it < 600; it++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            case (lfsr[11:8])
                4'd0, 4'd1: wa = 8'h20 | {5'd0, lfsr[14:12]};
                4'd2, 4'd3: wa = 8'h28 | {5'd0, lfsr[14:12]};
                4'd4:  wa = 8'h02;
                4'd5:  wa = 8'h03;
                4'd6:  wa = 8'h06;
                4'd7:  wa = 8'h07;
                4'd8:  wa = 8'h0A;
                4'd9:  wa = 8'h0B;
                4'd10: wa = 8'h08;
                4'd11, 4'd12: wa = 8'h0D;
                default: wa = 8'h31;
            endcase
            if (it % 7 == 0) look(8'(it % 14));
            drive(lfsr[7:0] & lfsr[23:16], lfsr[31:24] & lfsr[15:8], lfsr[17:16] & lfsr[19:18],
                  lfsr[20], wa, {lfsr[3:0], lfsr[31:4]});
        end
        idle(3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule